// File: doc/BRIEF.md
# Three-Share Masked Bit-Serial Feistel Round Engine

This block runs the lightweight bit-serial Feistel cipher round (left word updated with a rotate-by-two term, a rotate-by-one AND rotate-by-eight term, the right word and a round-key word; right word takes the old left word) on data held as three Boolean shares. The XOR of the three shares is the real cipher state at all times, but no logic cone that produces a new share bit ever sees all three shares of the same word. Each output share is formed from the other two shares only. It uses cross-product AND terms so that, taken together, the three share equations rebuild the full unmasked AND product.

Three identical share lanes run in lock-step under one controller. On every clock cycle of an encryption, each lane writes exactly one new left-word bit, so a round takes one cycle per word bit. The caller splits the plaintext into three shares and applies them in parallel with a start pulse. It then supplies one bit of each of the three round-key shares per cycle, least significant bit first, round after round. Random-mask generation and the key schedule are outside the block. When the last round finishes, the three ciphertext shares are held on the outputs and a done flag is raised.

Top module: `ti_round_core`

## Requirements
- R1: A start pulse drops done on the next clock edge. Done then stays low until exactly ROUNDS*WORD_W clock edges after the start edge, and rises on that edge.
- R2: Over the ROUNDS*WORD_W edges after a start, edge number s (counting from 1) uses bit (s-1) mod WORD_W of the three key shares of round (s-1)/WORD_W. When done is high, the XOR of the three output left shares and the XOR of the three output right shares equal the unmasked ciphertext. Here the plaintext and every round key are the XOR of their three shares, and the rotations are left circular.
- R3: For share i (0, 1, 2), let x be share (i+1) mod 3 and y be share (i+2) mod 3. The new left share i equals right_x ^ rol(left_x,2) ^ (rol(left_x,1) & rol(left_x,8)) ^ (rol(left_x,1) & rol(left_y,8)) ^ (rol(left_y,1) & rol(left_x,8)) ^ key_x.
- R4: At each round boundary, every right share takes the value that the same-numbered left share held during that round.
- R5: The unmasked result does not depend on the masks. The same plaintext and key, split with different masks, give the same output XOR.
- R6: While done is high and no start arrives, all output shares and done stay unchanged, whatever the key-share inputs do.
- R7: A start during an encryption abandons it and begins a new one with the newly applied shares. Timing and result then follow R1 and R2 from the new start.
- R8: After reset, done is low and all six output share words are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Load the input shares and begin an encryption |
| in_left_s0 | input | WORD_W | Plaintext left word, share 0 |
| in_left_s1 | input | WORD_W | Plaintext left word, share 1 |
| in_left_s2 | input | WORD_W | Plaintext left word, share 2 |
| in_right_s0 | input | WORD_W | Plaintext right word, share 0 |
| in_right_s1 | input | WORD_W | Plaintext right word, share 1 |
| in_right_s2 | input | WORD_W | Plaintext right word, share 2 |
| key_s0 | input | 1 | Serial round-key bit, share 0 |
| key_s1 | input | 1 | Serial round-key bit, share 1 |
| key_s2 | input | 1 | Serial round-key bit, share 2 |
| out_left_s0 | output | WORD_W | Ciphertext left word, share 0 |
| out_left_s1 | output | WORD_W | Ciphertext left word, share 1 |
| out_left_s2 | output | WORD_W | Ciphertext left word, share 2 |
| out_right_s0 | output | WORD_W | Ciphertext right word, share 0 |
| out_right_s1 | output | WORD_W | Ciphertext right word, share 1 |
| out_right_s2 | output | WORD_W | Ciphertext right word, share 2 |
| done | output | 1 | Encryption finished, outputs valid |

## Verification
The hardest case to reach is a wrong share routing that still yields the correct unmasked XOR. A swapped cross term, or a key share paired with the wrong lane, can cancel in the XOR. Checking the recombined ciphertext alone would miss it. The bench therefore keeps its own share-level model, driven by random masks and by random key shares whose XOR is the true round key. It compares every left and right share separately as well as the recombined word. Walking-one plaintexts under zero keys spread a single set bit through the rotations, so a misplaced tap shows up as a bit in the wrong place. A start issued partway through an encryption exercises the abandon-and-reload path.

// File: rtl/ti_round_pkg.sv
// Shared constants, controller state type and tap-index arithmetic for the
// three-share bit-serial round engine. Assumes rotation amounts below WORD_W
// are meaningful; larger values wrap modulo the word width.
package ti_round_pkg;

    localparam int NUM_SHARES = 3;
    localparam int ROT_LIN    = 2;  // linear rotate term
    localparam int ROT_AND_A  = 1;  // first AND operand rotation
    localparam int ROT_AND_B  = 8;  // second AND operand rotation

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } ctrl_state_e;

    // Bit position of rol(word, rot) at output position idx: idx - rot mod width.
    function automatic int unsigned tap_index(input int unsigned idx,
                                              input int unsigned rot,
                                              input int unsigned width);
        return (idx + width - (rot % width)) % width;
    endfunction

endpackage

// File: rtl/ti_share_func.sv
// Combinational cross-share round function for one output share bit.
// Uses only two input shares (x and y) plus the right bit and key bit of x.
// Assumes both left words are stable for the whole round.
module ti_share_func
    import ti_round_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int IDX_W  = 4
) (
    input  logic [WORD_W-1:0] x_left,
    input  logic [WORD_W-1:0] y_left,
    input  logic              x_right_bit,
    input  logic              x_key_bit,
    input  logic [IDX_W-1:0]  idx,
    output logic              new_bit
);

    logic [IDX_W-1:0] i_lin;
    logic [IDX_W-1:0] i_a;
    logic [IDX_W-1:0] i_b;
    logic x_lin, x_a, x_b, y_a, y_b;

    // Purpose: locate the rotated taps for the current bit position.
    always_comb begin
        i_lin = IDX_W'(tap_index(32'(idx), ROT_LIN,   WORD_W));
        i_a   = IDX_W'(tap_index(32'(idx), ROT_AND_A, WORD_W));
        i_b   = IDX_W'(tap_index(32'(idx), ROT_AND_B, WORD_W));
    end

    // Purpose: combine the taps into the new bit of this share.
    always_comb begin
        x_lin   = x_left[i_lin];
        x_a     = x_left[i_a];
        x_b     = x_left[i_b];
        y_a     = y_left[i_a];
        y_b     = y_left[i_b];
        new_bit = x_right_bit ^ x_lin ^ (x_a & x_b) ^ (x_a & y_b)
                ^ (y_a & x_b) ^ x_key_bit;
    end

endmodule

// File: rtl/ti_share_bank.sv
// Two-word storage for one share lane. One bank holds the old left word for
// the current round; the other holds the right word and is overwritten one
// bit per cycle with the new left word. Roles swap when old_sel toggles.
// Assumes the controller clears old_sel on every load.
module ti_share_bank #(
    parameter int WORD_W = 16,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] load_left,
    input  logic [WORD_W-1:0] load_right,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_bit,
    input  logic              old_sel,
    output logic [WORD_W-1:0] left_word,
    output logic [WORD_W-1:0] right_word,
    output logic              right_bit
);

    logic [1:0][WORD_W-1:0] bank;

    // Purpose: load both words, or write one new left bit into the spare bank.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank <= '0;
        end else if (load) begin
            bank[0] <= load_left;
            bank[1] <= load_right;
        end else if (wr_en) begin
            bank[~old_sel][wr_idx] <= wr_bit;
        end
    end

    // Purpose: present the current left/right views and the right bit in use.
    always_comb begin
        left_word  = bank[old_sel];
        right_word = bank[~old_sel];
        right_bit  = right_word[wr_idx];
    end

endmodule

// File: rtl/ti_round_ctrl.sv
// Single controller shared by all share lanes: bit index within the round,
// round counter, bank-role select and done state. A start always wins and
// restarts from round 0, bit 0.
module ti_round_ctrl
    import ti_round_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int ROUNDS = 32,
    parameter int IDX_W  = 4,
    parameter int RND_W  = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             load,
    output logic             wr_en,
    output logic [IDX_W-1:0] bit_idx,
    output logic             old_sel,
    output logic             round_end,
    output logic             done
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORD_W - 1);
    localparam logic [RND_W-1:0] LAST_RND = RND_W'(ROUNDS - 1);

    ctrl_state_e      state;
    logic [RND_W-1:0] round_cnt;

    // Purpose: decode per-cycle strobes from the state.
    always_comb begin
        load      = start;
        wr_en     = (state == ST_RUN) && !start;
        round_end = wr_en && (bit_idx == LAST_IDX);
        done      = (state == ST_DONE);
    end

    // Purpose: advance bit index, round count and bank roles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            bit_idx   <= '0;
            round_cnt <= '0;
            old_sel   <= 1'b0;
        end else if (start) begin
            state     <= ST_RUN;
            bit_idx   <= '0;
            round_cnt <= '0;
            old_sel   <= 1'b0;
        end else if (wr_en) begin
            if (bit_idx == LAST_IDX) begin
                bit_idx <= '0;
                old_sel <= ~old_sel;
                if (round_cnt == LAST_RND) begin
                    state     <= ST_DONE;
                    round_cnt <= '0;
                end else begin
                    round_cnt <= round_cnt + 1'b1;
                end
            end else begin
                bit_idx <= bit_idx + 1'b1;
            end
        end
    end

endmodule

// File: rtl/ti_round_core.sv
// Top of the three-share masked bit-serial round engine. Three lanes, each
// with its own bank and cross-share function, run under one controller.
// Lane i is computed from lanes (i+1) mod 3 and (i+2) mod 3 only.
// Assumes the caller supplies valid masked shares and key-share bits.
module ti_round_core
    import ti_round_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int ROUNDS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] in_left_s0,
    input  logic [WORD_W-1:0] in_left_s1,
    input  logic [WORD_W-1:0] in_left_s2,
    input  logic [WORD_W-1:0] in_right_s0,
    input  logic [WORD_W-1:0] in_right_s1,
    input  logic [WORD_W-1:0] in_right_s2,
    input  logic              key_s0,
    input  logic              key_s1,
    input  logic              key_s2,
    output logic [WORD_W-1:0] out_left_s0,
    output logic [WORD_W-1:0] out_left_s1,
    output logic [WORD_W-1:0] out_left_s2,
    output logic [WORD_W-1:0] out_right_s0,
    output logic [WORD_W-1:0] out_right_s1,
    output logic [WORD_W-1:0] out_right_s2,
    output logic              done
);

    localparam int IDX_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
    localparam int RND_W = (ROUNDS > 1) ? $clog2(ROUNDS) : 1;

    logic [NUM_SHARES-1:0][WORD_W-1:0] ld_left_all;
    logic [NUM_SHARES-1:0][WORD_W-1:0] ld_right_all;
    logic [NUM_SHARES-1:0][WORD_W-1:0] ct_left_all;
    logic [NUM_SHARES-1:0][WORD_W-1:0] ct_right_all;
    logic [NUM_SHARES-1:0]             key_all;
    logic [NUM_SHARES-1:0]             right_bit_all;
    logic [NUM_SHARES-1:0]             new_bit_all;

    logic             load_w;
    logic             wr_en_w;
    logic [IDX_W-1:0] bit_idx_w;
    logic             old_sel_w;
    logic             round_end_w;

    // Purpose: gather per-share ports into indexable arrays.
    always_comb begin
        ld_left_all  = {in_left_s2, in_left_s1, in_left_s0};
        ld_right_all = {in_right_s2, in_right_s1, in_right_s0};
        key_all      = {key_s2, key_s1, key_s0};
    end

    ti_round_ctrl #(
        .WORD_W (WORD_W),
        .ROUNDS (ROUNDS),
        .IDX_W  (IDX_W),
        .RND_W  (RND_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .load      (load_w),
        .wr_en     (wr_en_w),
        .bit_idx   (bit_idx_w),
        .old_sel   (old_sel_w),
        .round_end (round_end_w),
        .done      (done)
    );

    for (genvar g = 0; g < NUM_SHARES; g++) begin : g_share
        localparam int XS = (g + 1) % NUM_SHARES;
        localparam int YS = (g + 2) % NUM_SHARES;

        ti_share_bank #(
            .WORD_W (WORD_W),
            .IDX_W  (IDX_W)
        ) u_bank (
            .clk        (clk),
            .rst_n      (rst_n),
            .load       (load_w),
            .load_left  (ld_left_all[g]),
            .load_right (ld_right_all[g]),
            .wr_en      (wr_en_w),
            .wr_idx     (bit_idx_w),
            .wr_bit     (new_bit_all[g]),
            .old_sel    (old_sel_w),
            .left_word  (ct_left_all[g]),
            .right_word (ct_right_all[g]),
            .right_bit  (right_bit_all[g])
        );

        ti_share_func #(
            .WORD_W (WORD_W),
            .IDX_W  (IDX_W)
        ) u_func (
            .x_left      (ct_left_all[XS]),
            .y_left      (ct_left_all[YS]),
            .x_right_bit (right_bit_all[XS]),
            .x_key_bit   (key_all[XS]),
            .idx         (bit_idx_w),
            .new_bit     (new_bit_all[g])
        );
    end

    // Purpose: drive the per-share output ports.
    always_comb begin
        out_left_s0  = ct_left_all[0];
        out_left_s1  = ct_left_all[1];
        out_left_s2  = ct_left_all[2];
        out_right_s0 = ct_right_all[0];
        out_right_s1 = ct_right_all[1];
        out_right_s2 = ct_right_all[2];
    end

endmodule

// File: rtl/ti_round_checker.sv
// Protocol and share-handover checks for ti_round_core, attached by bind.
module ti_round_checker #(
    parameter int WORD_W = 16,
    parameter int ROUNDS = 32
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  start,
    input logic                  done,
    input logic                  round_end,
    input logic [2:0][WORD_W-1:0] ct_left,
    input logic [2:0][WORD_W-1:0] ct_right
);

    localparam int TOTAL = ROUNDS * WORD_W;
    localparam int CW    = $clog2(TOTAL + 1) + 1;

    logic [CW-1:0] since_start;

    // Purpose: count edges since the latest start, saturating at TOTAL.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_start <= '0;
        end else if (start) begin
            since_start <= '0;
        end else if (!done && since_start < CW'(TOTAL)) begin
            since_start <= since_start + 1'b1;
        end
    end

    // R1: done rises only after the full number of bit steps
    p_done_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (since_start == CW'(TOTAL)));

    // R1 and R7: any start clears done on the next edge
    p_start_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !done);

    // R6: finished results hold while idle
    p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(ct_left) && $stable(ct_right)));

    for (genvar g = 0; g < 3; g++) begin : g_chk
        // R4: right share takes the same share's old left word at a round end
        p_right_handover_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (round_end && !start) |=> (ct_right[g] == $past(ct_left[g])));
    end

endmodule

bind ti_round_core ti_round_checker #(
    .WORD_W (WORD_W),
    .ROUNDS (ROUNDS)
) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .done      (done),
    .round_end (round_end_w),
    .ct_left   (ct_left_all),
    .ct_right  (ct_right_all)
);

// File: tb/ti_round_core_tb.sv
`timescale 1ns/1ps
module ti_round_core_tb;

    localparam int W   = 16;
    localparam int RND = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [W-1:0] il0 = '0, il1 = '0, il2 = '0, ir0 = '0, ir1 = '0, ir2 = '0;
    logic k0 = 1'b0, k1 = 1'b0, k2 = 1'b0;
    logic [W-1:0] ol0, ol1, ol2, or0, or1, or2;
    logic done;

    int n_checks = 0;
    int n_fail = 0;
    int cycles = 0;

    logic [W-1:0] rk [0:RND-1];
    logic [W-1:0] ks [0:2][0:RND-1];
    logic [W-1:0] m1l, m1r, m2l, m2r;
    logic [W-1:0] last_xl, last_xr;

    ti_round_core #(.WORD_W(W), .ROUNDS(RND)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .in_left_s0(il0), .in_left_s1(il1), .in_left_s2(il2),
        .in_right_s0(ir0), .in_right_s1(ir1), .in_right_s2(ir2),
        .key_s0(k0), .key_s1(k1), .key_s2(k2),
        .out_left_s0(ol0), .out_left_s1(ol1), .out_left_s2(ol2),
        .out_right_s0(or0), .out_right_s1(or1), .out_right_s2(or2),
        .done(done)
    );

    always #4 clk = ~clk;

    task automatic summary_and_end();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cycles);
            summary_and_end();
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] rol(input logic [W-1:0] x, input int s);
        return (x << s) | (x >> (W - s));
    endfunction

    function automatic logic [W-1:0] fshare(input logic [W-1:0] x, y, rx, k);
        return rx ^ rol(x, 2) ^ (rol(x, 1) & rol(x, 8)) ^ (rol(x, 1) & rol(y, 8))
             ^ (rol(y, 1) & rol(x, 8)) ^ k;
    endfunction

    task automatic make_keys(input bit zero);
        for (int t = 0; t < RND; t++) begin
            rk[t]    = zero ? '0 : W'($urandom);
            ks[0][t] = W'($urandom);
            ks[1][t] = W'($urandom);
            ks[2][t] = rk[t] ^ ks[0][t] ^ ks[1][t];
        end
    endtask

    task automatic make_masks();
        m1l = W'($urandom); m1r = W'($urandom);
        m2l = W'($urandom); m2r = W'($urandom);
    endtask

    // Apply shares, start, feed key bits; abort_at >= 0 stops early without checking.
    task automatic run_enc(input logic [W-1:0] pl, input logic [W-1:0] pr, input int abort_at, input string tag);
        logic [W-1:0] sl [0:2];
        logic [W-1:0] sr [0:2];
        logic [W-1:0] nl [0:2];
        logic [W-1:0] ul, ur, tmp;
        int seen_done;
        @(negedge clk);
        il0 = m1l; il1 = m2l; il2 = pl ^ m1l ^ m2l;
        ir0 = m1r; ir1 = m2r; ir2 = pr ^ m1r ^ m2r;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(done == 1'b0, {"R1 done low after start ", tag}, done, 0);
        seen_done = 0;
        for (int s = 0; s < RND * W; s++) begin
            if (abort_at >= 0 && s == abort_at) return;
            k0 = ks[0][s / W][s % W];
            k1 = ks[1][s / W][s % W];
            k2 = ks[2][s / W][s % W];
            if (done) seen_done++;
            @(negedge clk);
        end
        chk(seen_done == 0, {"R1 done early ", tag}, seen_done, 0);
        chk(done == 1'b1, {"R1 done at final step ", tag}, done, 1);
        // unmasked reference
        ul = pl; ur = pr;
        for (int t = 0; t < RND; t++) begin
            tmp = ul;
            ul = ur ^ rol(ul, 2) ^ (rol(ul, 1) & rol(ul, 8)) ^ rk[t];
            ur = tmp;
        end
        // share-level reference
        sl[0] = m1l; sl[1] = m2l; sl[2] = pl ^ m1l ^ m2l;
        sr[0] = m1r; sr[1] = m2r; sr[2] = pr ^ m1r ^ m2r;
        for (int t = 0; t < RND; t++) begin
            for (int i = 0; i < 3; i++)
                nl[i] = fshare(sl[(i + 1) % 3], sl[(i + 2) % 3], sr[(i + 1) % 3], ks[(i + 1) % 3][t]);
            for (int i = 0; i < 3; i++) begin
                sr[i] = sl[i];
                sl[i] = nl[i];
            end
        end
        last_xl = ol0 ^ ol1 ^ ol2;
        last_xr = or0 ^ or1 ^ or2;
        chk(last_xl == ul, {"R2 left XOR ", tag}, last_xl, ul);
        chk(last_xr == ur, {"R2 right XOR ", tag}, last_xr, ur);
        chk({ol0, ol1, ol2} == {sl[0], sl[1], sl[2]}, {"R3 left shares ", tag},
            {ol0, ol1}, {sl[0], sl[1]});
        chk({or0, or1, or2} == {sr[0], sr[1], sr[2]}, {"R4 right shares ", tag},
            {or0, or1}, {sr[0], sr[1]});
    endtask

    initial begin
        logic [W-1:0] hl0, hl1, hl2, hr0, hr1, hr2;
        logic [W-1:0] refl, refr, pl, pr;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8: reset state
        chk(done == 1'b0, "R8 done after reset", done, 0);
        chk({ol0, ol1, ol2, or0, or1, or2} == '0, "R8 outputs zero after reset", {ol0, or0}, 0);

        // Walking one through both words, zero keys, random masks (R2, R3, R4)
        make_keys(1'b1);
        for (int b = 0; b < 2 * W; b++) begin
            make_masks();
            run_enc((b < W) ? W'(1 << b) : '0, (b >= W) ? W'(1 << (b - W)) : '0, -1, "walk");
        end

        // Random sweep with random key shares
        for (int n = 0; n < 60; n++) begin
            make_keys(1'b0);
            make_masks();
            run_enc(W'($urandom), W'($urandom), -1, "random");
        end

        // R5: same data and key under several masks
        make_keys(1'b0);
        pl = W'($urandom); pr = W'($urandom);
        make_masks();
        run_enc(pl, pr, -1, "R5 base");
        refl = last_xl; refr = last_xr;
        for (int n = 0; n < 4; n++) begin
            make_masks();
            for (int t = 0; t < RND; t++) begin
                ks[0][t] = W'($urandom);
                ks[1][t] = W'($urandom);
                ks[2][t] = rk[t] ^ ks[0][t] ^ ks[1][t];
            end
            run_enc(pl, pr, -1, "R5 remask");
            chk({last_xl, last_xr} == {refl, refr}, "R5 mask independence", {last_xl, last_xr}, {refl, refr});
        end

        // R6: hold while done with toggling key inputs
        hl0 = ol0; hl1 = ol1; hl2 = ol2; hr0 = or0; hr1 = or1; hr2 = or2;
        for (int c = 0; c < 20; c++) begin
            k0 = ~k0; k1 = c[0]; k2 = c[1];
            @(negedge clk);
        end
        chk(done == 1'b1, "R6 done held", done, 1);
        chk({ol0, ol1, ol2, or0, or1, or2} == {hl0, hl1, hl2, hr0, hr1, hr2},
            "R6 outputs held", {ol0, or0}, {hl0, hr0});

        // R7: abort partway, then restart with new data
        make_keys(1'b0);
        make_masks();
        run_enc(W'($urandom), W'($urandom), W * 3 + 5, "R7 aborted");
        make_keys(1'b0);
        make_masks();
        run_enc(W'($urandom), W'($urandom), -1, "R7 restart");
        make_masks();
        run_enc(W'($urandom), W'($urandom), 1, "R7 aborted early");
        run_enc(16'hA5C3, 16'h0F1E, -1, "R7 restart after early abort");

        // R8: reset mid-state clears outputs
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk(done == 1'b0, "R8 done after second reset", done, 0);
        chk({ol0, ol1, ol2, or0, or1, or2} == '0, "R8 outputs cleared", {ol0, or0}, 0);

        summary_and_end();
    end

endmodule